// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Processor

This block is a small processor built around one 16-bit accumulator. A sequencer walks through fetch, decode and execute, and then starts over. It reads its instructions and its operands through a single memory port, so code and data share one address space. Each instruction word is split into two fields. The upper four bits select the operation. The lower twelve bits give a direct word address.

Eight operations are defined:

- load, store, add and subtract against memory;
- an unconditional jump;
- a jump taken when the accumulator is non-negative;
- a jump taken when the accumulator is nonzero;
- stop.

The remaining eight operation codes do nothing. After a stop, the `halted` output goes high and the core freezes until the next reset.

The memory attached to the port must return read data exactly one clock after it sees the address. The memory must also write `mem_wdata` into the word at `mem_addr` on any clock edge where `mem_we` is high.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held, and in the first cycle after it, `halted` and `mem_we` are 0 and `mem_addr` is 0. The program counter and accumulator start at zero.
- R2: An instruction word has two fields. Bits 15:12 hold the operation code and bits 11:0 hold the operand word address S.
- R3: Code 0 loads the accumulator from mem[S]. Code 2 adds mem[S] to it and code 3 subtracts mem[S] from it. Both wrap modulo 2^16 and no overflow is flagged.
- R4: Code 4 always jumps to S. Code 5 jumps to S when accumulator bit 15 is 0. Code 6 jumps to S when the accumulator is not zero. A jump that is not taken falls through to the next word.
- R5: Code 7 stops the core. From then until reset, `halted` stays 1, `mem_we` stays 0, `mem_addr` holds its value, and memory is not changed.
- R6: Codes 8 to 15 change neither the accumulator nor memory, and execution continues at the next word.
- R7: The program counter steps by one modulo 4096 after each fetch. Load, add and subtract take 5 cycles each. Every other instruction takes 4 cycles. A program therefore reaches `halted` after the sum of these counts, with the stop instruction contributing 4.
- R8: `mem_we` is high for exactly one cycle per executed code 1. During that cycle `mem_addr` is S and `mem_wdata` is the accumulator. At all other times `mem_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Word address: the program counter during fetch, the operand field during data access |
| mem_wdata | output | 16 | Store data, which is the accumulator |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
The bench targets the boundaries of wrapping arithmetic:

- 0x7FFF plus 1 must give 0x8000, and 0 minus 1 must give 0xFFFF. A core with the wrong carry or borrow would store different words.
- The two conditional jumps are run on 0x8000 and on 0. A core that tests the wrong bit, or mixes up the non-negative and nonzero tests, ends up writing marker words that should stay untouched.

Code words 8 to 15 carry an operand pointing at a guarded word. A core that treats them as stores corrupts that word.

After a stop, the bench keeps clocking. It watches for any strobe or address movement, which would show a core that keeps fetching.

Random programs are compared against a bench model on both final memory and the exact cycle count. This catches a missing or extra wait state, and a program counter that is off by one.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);
  localparam int OP_W = DATA_W - ADDR_W;
  localparam logic [OP_W-1:0] OP_LOAD  = OP_W'(0);
  localparam logic [OP_W-1:0] OP_STORE = OP_W'(1);
  localparam logic [OP_W-1:0] OP_ADD   = OP_W'(2);
  localparam logic [OP_W-1:0] OP_SUB   = OP_W'(3);
  localparam logic [OP_W-1:0] OP_JMP   = OP_W'(4);
  localparam logic [OP_W-1:0] OP_JPOS  = OP_W'(5);
  localparam logic [OP_W-1:0] OP_JNZ   = OP_W'(6);
  localparam logic [OP_W-1:0] OP_STOP  = OP_W'(7);

  typedef enum logic [2:0] {S_FETCH, S_FWAIT, S_DECODE, S_EXEC, S_XWAIT, S_HALT} state_t;

  state_t            state;
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir, acc;

  wire [OP_W-1:0]   op      = ir[DATA_W-1 -: OP_W];
  wire [ADDR_W-1:0] operand = ir[ADDR_W-1:0];
  wire reads_mem = (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB);
  wire take_jump = (op == OP_JMP) ||
                   ((op == OP_JPOS) && !acc[DATA_W-1]) ||
                   ((op == OP_JNZ) && (acc != '0));

  assign mem_addr  = (state == S_EXEC || state == S_XWAIT) ? operand : pc;
  assign mem_we    = (state == S_EXEC) && (op == OP_STORE);
  assign mem_wdata = acc;
  assign halted    = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= '0;
      ir    <= '0;
      acc   <= '0;
    end else begin
      case (state)
        S_FETCH:  state <= S_FWAIT;
        S_FWAIT: begin
          ir    <= mem_rdata;
          pc    <= pc + 1'b1;
          state <= S_DECODE;
        end
        S_DECODE: state <= S_EXEC;
        S_EXEC: begin
          if (op == OP_STOP)  state <= S_HALT;
          else if (reads_mem) state <= S_XWAIT;
          else                state <= S_FETCH;
          if (take_jump) pc <= operand;
        end
        S_XWAIT: begin
          case (op)
            OP_ADD:  acc <= acc + mem_rdata;
            OP_SUB:  acc <= acc - mem_rdata;
            default: acc <= mem_rdata;
          endcase
          state <= S_FETCH;
        end
        default:  state <= S_HALT;
      endcase
    end
  end

  p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_FWAIT |=> pc == ADDR_W'($past(pc) + 1'b1));

  p_acc_only_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_XWAIT |=> $stable(acc));

  p_store_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  p_halt_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  p_halt_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(mem_addr));
endmodule

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_we, halted;

  logic [15:0] mem [256];
  logic [15:0] ref_mem [256];
  logic [15:0] prog [256];
  int checks = 0, failures = 0;
  int wd = 0;

  always #5 clk = ~clk;

  acc_cpu dut (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
               .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted));

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ref_run(output int cyc, output bit ok);
    logic [11:0] pc = 0;
    logic [15:0] acc = 0;
    logic [15:0] w;
    logic [7:0]  s;
    ok = 0; cyc = 0;
    for (int n = 0; n < 400; n++) begin
      w = ref_mem[pc[7:0]];
      pc = pc + 1;
      cyc += 4;
      s = w[7:0];
      case (w[15:12])
        4'd0: begin acc = ref_mem[s]; cyc++; end
        4'd1: ref_mem[s] = acc;
        4'd2: begin acc = acc + ref_mem[s]; cyc++; end
        4'd3: begin acc = acc - ref_mem[s]; cyc++; end
        4'd4: pc = w[11:0];
        4'd5: if (!acc[15]) pc = w[11:0];
        4'd6: if (acc != 0) pc = w[11:0];
        4'd7: begin ok = 1; return; end
        default: ;
      endcase
    end
  endtask

  task automatic run_prog(input string tag);
    int exp_cyc, cyc, bad;
    bit ok;
    logic [11:0] hold;
    for (int i = 0; i < 256; i++) ref_mem[i] = prog[i];
    ref_run(exp_cyc, ok);
    @(negedge clk);
    rst_n = 0;
    for (int i = 0; i < 256; i++) mem[i] = prog[i];
    repeat (2) @(negedge clk);
    chk(!halted && !mem_we && mem_addr == 0, {"R1 reset state ", tag}, {halted, mem_we, mem_addr}, 0);
    rst_n = 1;
    #1 chk(!halted && !mem_we && mem_addr == 0, {"R1 first cycle ", tag}, {halted, mem_we, mem_addr}, 0);
    cyc = 0;
    while (!halted && cyc < 3000) begin
      @(posedge clk); #1 cyc++;
    end
    chk(cyc == exp_cyc, {"R7 cycles to halt ", tag}, cyc, exp_cyc);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
    chk(bad == 0, {"R3 R8 final memory ", tag}, bad, 0);
    hold = mem_addr;
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #1;
      if (!halted || mem_we || mem_addr != hold) bad++;
    end
    for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
    chk(bad == 0, {"R5 quiet after stop ", tag}, bad, 0);
  endtask

  function automatic logic [15:0] ins(input int op, input int s);
    return {op[3:0], s[11:0]};
  endfunction

  initial begin
    void'($urandom(32'd20240611));

    for (int i = 0; i < 256; i++) prog[i] = 16'h7000;
    prog[100] = 16'h7FFF; prog[101] = 16'h0001; prog[102] = 16'h0000; prog[103] = 16'hFFFF;
    prog[0] = ins(0, 100); prog[1] = ins(2, 101); prog[2] = ins(1, 110);
    prog[3] = ins(0, 102); prog[4] = ins(3, 101); prog[5] = ins(1, 111);
    prog[6] = ins(0, 103); prog[7] = ins(2, 103); prog[8] = ins(1, 112);
    prog[9] = ins(7, 0);
    run_prog("arith");
    chk(mem[110] == 16'h8000, "R3 0x7FFF+1 wraps", mem[110], 16'h8000);
    chk(mem[111] == 16'hFFFF, "R3 0-1 wraps", mem[111], 16'hFFFF);
    chk(mem[112] == 16'hFFFE, "R3 R2 0xFFFF+0xFFFF", mem[112], 16'hFFFE);

    for (int i = 0; i < 256; i++) prog[i] = 16'h7000;
    prog[100] = 16'h8000; prog[101] = 16'h0005; prog[102] = 16'h0000;
    for (int i = 110; i < 115; i++) prog[i] = 16'hDEAD;
    prog[0] = ins(0, 100); prog[1] = ins(5, 20); prog[2] = ins(6, 4);
    prog[3] = ins(1, 110); prog[4] = ins(0, 102); prog[5] = ins(6, 20);
    prog[6] = ins(5, 8);   prog[7] = ins(1, 111); prog[8] = ins(0, 101);
    prog[9] = ins(1, 112); prog[10] = ins(4, 12); prog[11] = ins(1, 113);
    prog[12] = ins(7, 0);  prog[20] = ins(1, 114);
    run_prog("branch");
    chk(mem[110] == 16'hDEAD, "R4 nonzero jump taken on 0x8000", mem[110], 16'hDEAD);
    chk(mem[111] == 16'hDEAD, "R4 non-negative jump taken on 0", mem[111], 16'hDEAD);
    chk(mem[112] == 16'h0005, "R4 fall-through path", mem[112], 16'h0005);
    chk(mem[113] == 16'hDEAD, "R4 unconditional jump", mem[113], 16'hDEAD);
    chk(mem[114] == 16'hDEAD, "R4 untaken jumps fall through", mem[114], 16'hDEAD);

    for (int i = 0; i < 256; i++) prog[i] = 16'h7000;
    prog[100] = 16'h1234; prog[110] = 16'hBEEF;
    prog[0] = ins(0, 100);
    for (int k = 0; k < 8; k++) prog[1 + k] = ins(8 + k, 110);
    prog[9] = ins(1, 111); prog[10] = ins(7, 0);
    run_prog("nop");
    chk(mem[110] == 16'hBEEF, "R6 codes 8-15 leave memory", mem[110], 16'hBEEF);
    chk(mem[111] == 16'h1234, "R6 codes 8-15 leave accumulator", mem[111], 16'h1234);

    for (int t = 0; t < 24; t++) begin
      bit ok = 0;
      int c;
      while (!ok) begin
        for (int i = 0; i < 256; i++) prog[i] = (i >= 128) ? 16'($urandom) : 16'h7000;
        for (int i = 0; i < 40; i++) begin
          int op = $urandom % 16;
          if (op >= 4 && op <= 6) prog[i] = ins(op, $urandom % 48);
          else if (op == 7 && ($urandom % 4 != 0)) prog[i] = ins(2, 128 + $urandom % 128);
          else prog[i] = ins(op, 128 + $urandom % 128);
        end
        for (int i = 0; i < 256; i++) ref_mem[i] = prog[i];
        ref_run(c, ok);
      end
      run_prog("random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule